// File: doc/BRIEF.md
# Lamp Channel Fault Supervisor

This block sequences eight lamp channels of a backlight inverter through their life cycle: wait for good supplies, strike, run, and react to faults. Every timing window is measured in lamp cycles, delivered as a single-clock `lamp_tick` pulse, so the same logic works at any lamp frequency. Analog sensing is outside the block: lamp current presence, overvoltage and overcurrent arrive as per-channel digital flags, and the outputs are per-channel gate-drive enables plus one active-low fault line.

Each channel owns its own state, cycle counter and retry counter. A lost strike, an extinguished lamp or an overvoltage sends the channel into a retry pause followed by a new strike. The retry budget is limited. An overcurrent, when its detection is enabled, latches the fault at once without retrying. A latched fault holds until one of the two supply flags drops and returns. A configuration bit decides whether a latched fault silences only its own channel or every channel. A 3-bit code switches off fixed subsets of channels for panels with fewer lamps.

Top module: `lamp_fault_supervisor`

## Requirements
- R1: No `gate_en` bit is high in the cycle after a clock edge at which `dev_ok` or `inv_ok` was low. When both flags are high, an enabled idle channel starts striking one edge later.
- R2: A striking channel drives its gates for exactly 768 lamp ticks without seen current, then stops and enters retry handling. A tick with current present moves the channel to run.
- R3: A running channel whose `cur_ok` stays low for 256 consecutive ticks stops and enters retry handling. Any tick with current present restarts that count.
- R4: An `ovp` flag on a striking or running channel turns its gate enable off at the next edge and enters retry handling.
- R5: With `cfg_ocp_en`=1, an `ocp` flag on a driven channel latches the fault at the next edge, and the channel never restrikes. With `cfg_ocp_en`=0, `ocp` has no effect.
- R6: Retry handling keeps the gates off for 1024 ticks and then strikes again. A strike that then sees current resumes normal running.
- R7: The fault latches only when handling is entered with 15 retries already used, so the 16th failed strike latches it. With `cfg_retry_off`=1, the first handling latches it.
- R8: While any channel holds a latched fault, `fault_n` is 0 and that channel's gates stay off for as long as both supplies stay good. A low supply flag clears the latch at the next edge.
- R9: With `cfg_all_off`=0, a latched fault switches off only its own channel. With `cfg_all_off`=1, every `gate_en` bit is 0 while any fault is latched.
- R10: `cfg_lamp_mask` disables channels (bit 0 = channel 1). Code 0 disables none, 1 disables {8}, 2 {4,8}, 3 {2,4,8}, 4 {2,4,6,8}, 5 {2,4,6,7,8}, 6 {2,3,4,6,7,8}, 7 all but 1. A disabled channel drops its gate at the next edge and never latches a fault.
- R11: Strike, extinguish and retry counters advance only on edges where `lamp_tick` is 1.
- R12: The retry count restarts at zero each time the supplies return, so a fresh failure after a supply cycle pauses instead of latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lamp_tick | input | 1 | One-clock pulse per lamp cycle |
| dev_ok | input | 1 | Controller supply adequate |
| inv_ok | input | 1 | Inverter supply adequate |
| cur_ok | input | 8 | Per-channel lamp current above open-lamp level |
| ovp | input | 8 | Per-channel overvoltage flag |
| ocp | input | 8 | Per-channel overcurrent flag |
| cfg_ocp_en | input | 1 | Enable overcurrent detection |
| cfg_retry_off | input | 1 | 1 = no automatic restrike |
| cfg_all_off | input | 1 | 1 = any latched fault silences all channels |
| cfg_lamp_mask | input | 3 | Lamp-disable code |
| gate_en | output | 8 | Per-channel gate-drive enable |
| fault_n | output | 1 | Active-low latched-fault indication |

## Verification
Two functions can land on the same edge: an overcurrent and an overvoltage can arrive together on a driven channel, and a latched fault on one channel can coincide with activity on the others under the all-channels scope. The bench drives an overcurrent on one channel while its neighbours run, under both scope settings, and judges the outcome from `gate_en` and `fault_n` one edge later and again long after the 1024-tick retry pause would have expired. Strike and retry windows are checked at the exact tick counts on both sides of each boundary.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int LFS_NCH = 8;

    typedef enum logic [2:0] {
        CH_IDLE   = 3'd0,
        CH_STRIKE = 3'd1,
        CH_RUN    = 3'd2,
        CH_WAIT   = 3'd3,
        CH_FAULT  = 3'd4
    } ch_state_e;
endpackage

// File: rtl/lfs_lamp_mask.sv
module lfs_lamp_mask
    import lfs_pkg::*;
(
    input  logic [2:0]         code_i,
    output logic [LFS_NCH-1:0] enable_o
);
    logic [LFS_NCH-1:0] off_d;

    // bit 0 is channel 1
    always_comb begin
        case (code_i)
            3'd0:    off_d = 8'b0000_0000;
            3'd1:    off_d = 8'b1000_0000;
            3'd2:    off_d = 8'b1000_1000;
            3'd3:    off_d = 8'b1000_1010;
            3'd4:    off_d = 8'b1010_1010;
            3'd5:    off_d = 8'b1110_1010;
            3'd6:    off_d = 8'b1110_1110;
            default: off_d = 8'b1111_1110;
        endcase
        enable_o = ~off_d;
    end
endmodule

// File: rtl/lfs_channel.sv
module lfs_channel
    import lfs_pkg::*;
#(
    parameter int STRIKE_CYC = 768,
    parameter int OPEN_CYC   = 256,
    parameter int WAIT_CYC   = 1024,
    parameter int MAX_RETRY  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lamp_tick,
    input  logic supply_ok,
    input  logic ch_enable,
    input  logic kill,
    input  logic cur_ok,
    input  logic ovp,
    input  logic ocp,
    input  logic cfg_ocp_en,
    input  logic cfg_retry_off,
    output logic gate_o,
    output logic faulted_o
);
    localparam int CNT_MAX = (STRIKE_CYC > OPEN_CYC)
                           ? ((STRIKE_CYC > WAIT_CYC) ? STRIKE_CYC : WAIT_CYC)
                           : ((OPEN_CYC > WAIT_CYC) ? OPEN_CYC : WAIT_CYC);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam int RW = $clog2(MAX_RETRY + 1);
    localparam logic [CW-1:0] STRIKE_LAST = CW'(STRIKE_CYC - 1);
    localparam logic [CW-1:0] OPEN_LAST   = CW'(OPEN_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST   = CW'(WAIT_CYC - 1);
    localparam logic [RW-1:0] RETRY_LIM   = RW'(MAX_RETRY);

    typedef struct packed {
        ch_state_e     st;
        logic [CW-1:0] cnt;
        logic [RW-1:0] retry;
    } ch_reg_t;

    ch_reg_t r_q, r_d;
    logic    handle_d;

    always_comb begin
        r_d      = r_q;
        handle_d = 1'b0;
        case (r_q.st)
            CH_IDLE: begin
                r_d.st  = CH_STRIKE;
                r_d.cnt = '0;
            end
            CH_STRIKE, CH_RUN: begin
                if (cfg_ocp_en && ocp) begin
                    r_d.st = CH_FAULT;
                end else if (ovp) begin
                    handle_d = 1'b1;
                end else if (lamp_tick) begin
                    if (cur_ok) begin
                        r_d.st  = CH_RUN;
                        r_d.cnt = '0;
                    end else if ((r_q.st == CH_STRIKE && r_q.cnt == STRIKE_LAST) ||
                                 (r_q.st == CH_RUN && r_q.cnt == OPEN_LAST)) begin
                        handle_d = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            CH_WAIT: begin
                if (lamp_tick) begin
                    if (r_q.cnt == WAIT_LAST) begin
                        r_d.st  = CH_STRIKE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = CH_FAULT;
        endcase

        if (handle_d) begin
            if (cfg_retry_off || r_q.retry == RETRY_LIM) begin
                r_d.st = CH_FAULT;
            end else begin
                r_d.st    = CH_WAIT;
                r_d.cnt   = '0;
                r_d.retry = r_q.retry + 1'b1;
            end
        end

        if (kill && r_q.st != CH_IDLE) begin
            r_d.st = CH_FAULT;
        end

        // supply loss or channel disable clears everything (R12)
        if (!supply_ok || !ch_enable) begin
            r_d.st    = CH_IDLE;
            r_d.cnt   = '0;
            r_d.retry = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= CH_IDLE;
            r_q.cnt   <= '0;
            r_q.retry <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o    = (r_q.st == CH_STRIKE || r_q.st == CH_RUN) && !kill;
    assign faulted_o = (r_q.st == CH_FAULT);

    a_r1_no_drive_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !gate_o);

    a_r4_ovp_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && ovp && supply_ok && ch_enable) |=> !gate_o);

    a_r5_ocp_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && ocp && cfg_ocp_en && supply_ok && ch_enable) |=> faulted_o);

    a_r7_wait_uses_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CH_WAIT) |-> (r_q.retry != '0));

    a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (faulted_o && supply_ok && ch_enable) |=> faulted_o);

    a_r10_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enable |=> (!gate_o && !faulted_o));
endmodule

// File: rtl/lamp_fault_supervisor.sv
module lamp_fault_supervisor
    import lfs_pkg::*;
#(
    parameter int STRIKE_CYC = 768,
    parameter int OPEN_CYC   = 256,
    parameter int WAIT_CYC   = 1024,
    parameter int MAX_RETRY  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lamp_tick,
    input  logic       dev_ok,
    input  logic       inv_ok,
    input  logic [7:0] cur_ok,
    input  logic [7:0] ovp,
    input  logic [7:0] ocp,
    input  logic       cfg_ocp_en,
    input  logic       cfg_retry_off,
    input  logic       cfg_all_off,
    input  logic [2:0] cfg_lamp_mask,
    output logic [7:0] gate_en,
    output logic       fault_n
);
    logic               supply_ok;
    logic               kill;
    logic [LFS_NCH-1:0] ch_en;
    logic [LFS_NCH-1:0] ch_fault;

    assign supply_ok = dev_ok & inv_ok;
    assign kill      = cfg_all_off & (|ch_fault);
    assign fault_n   = ~(|ch_fault);

    lfs_lamp_mask u_mask (
        .code_i   (cfg_lamp_mask),
        .enable_o (ch_en)
    );

    for (genvar i = 0; i < LFS_NCH; i++) begin : g_ch
        lfs_channel #(
            .STRIKE_CYC (STRIKE_CYC),
            .OPEN_CYC   (OPEN_CYC),
            .WAIT_CYC   (WAIT_CYC),
            .MAX_RETRY  (MAX_RETRY)
        ) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .lamp_tick     (lamp_tick),
            .supply_ok     (supply_ok),
            .ch_enable     (ch_en[i]),
            .kill          (kill),
            .cur_ok        (cur_ok[i]),
            .ovp           (ovp[i]),
            .ocp           (ocp[i]),
            .cfg_ocp_en    (cfg_ocp_en),
            .cfg_retry_off (cfg_retry_off),
            .gate_o        (gate_en[i]),
            .faulted_o     (ch_fault[i])
        );
    end

    a_r9_all_channels_silenced: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_all_off && !fault_n) |-> (gate_en == '0));

    a_r8_fault_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && supply_ok && $stable(cfg_lamp_mask)) |=> !fault_n);
endmodule

// File: tb/lamp_fault_supervisor_tb.sv
module lamp_fault_supervisor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lamp_tick = 1'b1;
    logic       dev_ok = 1'b0, inv_ok = 1'b0;
    logic [7:0] cur_ok = '0, ovp = '0, ocp = '0;
    logic       cfg_ocp_en = 1'b0, cfg_retry_off = 1'b0, cfg_all_off = 1'b0;
    logic [2:0] cfg_lamp_mask = '0;
    logic [7:0] gate_en;
    logic       fault_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lamp_fault_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .lamp_tick(lamp_tick),
        .dev_ok(dev_ok), .inv_ok(inv_ok),
        .cur_ok(cur_ok), .ovp(ovp), .ocp(ocp),
        .cfg_ocp_en(cfg_ocp_en), .cfg_retry_off(cfg_retry_off),
        .cfg_all_off(cfg_all_off), .cfg_lamp_mask(cfg_lamp_mask),
        .gate_en(gate_en), .fault_n(fault_n)
    );

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic restart();
        dev_ok = 1'b0; inv_ok = 1'b0;
        adv(2);
        cur_ok = '0; ovp = '0; ocp = '0; lamp_tick = 1'b1;
        cfg_ocp_en = 0; cfg_retry_off = 0; cfg_all_off = 0; cfg_lamp_mask = '0;
    endtask

    task automatic power_on();
        dev_ok = 1'b1; inv_ok = 1'b1;
    endtask

    task automatic t_reset_and_supply();
        chk("R1 reset gate", gate_en, 8'h00);
        chk("R1 reset fault", {7'd0, fault_n}, 8'h01);
        cur_ok = 8'hFF;
        dev_ok = 1; inv_ok = 0; adv(5);
        chk("R1 inverter low", gate_en, 8'h00);
        dev_ok = 0; inv_ok = 1; adv(5);
        chk("R1 device low", gate_en, 8'h00);
        dev_ok = 1; adv(1);
        chk("R1 both good", gate_en, 8'hFF);
        dev_ok = 0; adv(1);
        chk("R1 drop", gate_en, 8'h00);
    endtask

    task automatic t_extinguish();
        restart(); cur_ok = 8'hFF; power_on();
        adv(2);
        cur_ok = 8'hFB;
        adv(255);
        chk("R3 before 256", gate_en, 8'hFF);
        adv(1);
        chk("R3 at 256", gate_en, 8'hFB);
        chk("R3 no latch", {7'd0, fault_n}, 8'h01);
    endtask

    task automatic t_strike_retry();
        restart(); cfg_lamp_mask = 3'd7; power_on();
        adv(768);
        chk("R2 strike 768", gate_en, 8'h01);
        adv(1);
        chk("R2 strike timeout", gate_en, 8'h00);
        chk("R2 no latch", {7'd0, fault_n}, 8'h01);
        adv(1023);
        chk("R6 pause", gate_en, 8'h00);
        adv(1);
        chk("R6 restrike", gate_en, 8'h01);
        cur_ok = 8'h01;
        adv(300);
        chk("R6 resume run", gate_en, 8'h01);
    endtask

    task automatic t_ovp();
        restart(); cur_ok = 8'hFF; power_on();
        adv(3);
        ovp = 8'h02; adv(1); ovp = 8'h00;
        chk("R4 ovp run", gate_en, 8'hFD);
        chk("R4 no latch", {7'd0, fault_n}, 8'h01);
        restart(); power_on();
        adv(1);
        ovp = 8'h04; adv(1); ovp = 8'h00;
        chk("R4 ovp strike", gate_en, 8'hFB);
    endtask

    task automatic t_ocp_single();
        restart(); cur_ok = 8'hFF; power_on();
        adv(3);
        ocp = 8'h01; adv(10);
        chk("R5 ocp ignored", gate_en, 8'hFF);
        chk("R5 ocp ignored fault", {7'd0, fault_n}, 8'h01);
        cfg_ocp_en = 1; adv(1);
        chk("R9 single scope", gate_en, 8'hFE);
        chk("R5 ocp latch", {7'd0, fault_n}, 8'h00);
        ocp = 8'h00; adv(2000);
        chk("R5 no retry", gate_en, 8'hFE);
        chk("R8 fault held", {7'd0, fault_n}, 8'h00);
    endtask

    task automatic t_ocp_all();
        restart(); cfg_all_off = 1; cfg_ocp_en = 1; cur_ok = 8'hFF; power_on();
        adv(3);
        ocp = 8'h10; ovp = 8'h10; adv(1); ocp = 8'h00; ovp = 8'h00;
        chk("R9 all off", gate_en, 8'h00);
        chk("R9 fault", {7'd0, fault_n}, 8'h00);
        adv(1500);
        chk("R9 all stay off", gate_en, 8'h00);
    endtask

    task automatic t_retry_limit();
        restart(); cfg_lamp_mask = 3'd7; power_on();
        adv(27648);
        chk("R7 before limit", {7'd0, fault_n}, 8'h01);
        adv(1);
        chk("R7 limit latch", {7'd0, fault_n}, 8'h00);
        chk("R7 gate off", gate_en, 8'h00);
        adv(3000);
        chk("R8 sticky", {7'd0, fault_n}, 8'h00);
        chk("R8 sticky gate", gate_en, 8'h00);
        inv_ok = 0; adv(1);
        chk("R8 clear on supply", {7'd0, fault_n}, 8'h01);
        inv_ok = 1; adv(769);
        chk("R12 retry count reset", {7'd0, fault_n}, 8'h01);
        chk("R12 pausing", gate_en, 8'h00);
    endtask

    task automatic t_retry_off();
        restart(); cfg_retry_off = 1; cfg_lamp_mask = 3'd7; power_on();
        adv(768);
        chk("R7 retry off before", {7'd0, fault_n}, 8'h01);
        adv(1);
        chk("R7 retry off latch", {7'd0, fault_n}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] exp_on [8];
        exp_on[0] = 8'hFF; exp_on[1] = 8'h7F; exp_on[2] = 8'h77; exp_on[3] = 8'h75;
        exp_on[4] = 8'h55; exp_on[5] = 8'h15; exp_on[6] = 8'h11; exp_on[7] = 8'h01;
        for (int c = 0; c < 8; c++) begin
            restart(); cfg_lamp_mask = 3'(c); cur_ok = 8'hFF; power_on();
            adv(2);
            chk("R10 mask code", gate_en, exp_on[c]);
        end
        cfg_ocp_en = 1; ocp = 8'h80; adv(5); ocp = 8'h00;
        chk("R10 disabled no fault", {7'd0, fault_n}, 8'h01);
        cfg_lamp_mask = 3'd0; adv(3);
        cfg_lamp_mask = 3'd1; adv(1);
        chk("R10 live disable", gate_en, 8'h7F);
    endtask

    task automatic t_tick_gate();
        restart(); cfg_lamp_mask = 3'd7; lamp_tick = 0; power_on();
        adv(2000);
        chk("R11 no ticks", gate_en, 8'h01);
        lamp_tick = 1; adv(767);
        chk("R11 before timeout", gate_en, 8'h01);
        adv(1);
        chk("R11 timeout in ticks", gate_en, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        adv(1);
        t_reset_and_supply();
        t_extinguish();
        t_strike_retry();
        t_ovp();
        t_ocp_single();
        t_ocp_all();
        t_retry_limit();
        t_retry_off();
        t_mask();
        t_tick_gate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule